// File: doc/BRIEF.md
# Dual-Port Memory Access Permission Checker

This block sits between two independent system request ports and the memory behind them. It accepts a request on either port through a valid/ready handshake and judges it against a shared region security configuration. Each request carries an address, a read/write direction, a secure flag, a 4-bit non-secure access ID and a debug flag. A request that is allowed is presented on that port's forward side one cycle after acceptance. A request that is refused is never forwarded. Instead it gets a one-cycle error response on the same port.

The configuration is held in a small register bank with its own write and read channel. It has three parts. A 32-bit attribute word has its two top bits enabling secure accesses. A 32-bit ID-access word holds one read-enable bit and one write-enable bit for each of the 16 non-secure IDs. A control bit lets debug requests bypass the check. A refusal on either port raises one shared sticky interrupt. The first refusal also latches the failing address, port and direction for software. Software drops the interrupt by writing a 1 to a clear bit.

Top module: `mem_perm_guard`

## Requirements
- R1: A secure read is allowed only when bit 30 of the attribute word is set. A secure write is allowed only when bit 31 is set. The ID-access word has no effect on secure requests.
- R2: A non-secure read with ID n is allowed only when bit n of the ID-access word is set. A non-secure write with ID n is allowed only when bit 16+n is set. The attribute word has no effect on non-secure requests.
- R3: When bit 0 of the control register is 1, every request with the debug flag set is allowed whatever the permission bits hold. When that bit is 0, the debug flag has no effect on the decision.
- R4: An allowed request raises fwd_valid on its port in the cycle after acceptance, carrying the same address and direction. The request stays presented and stable while fwd_ready is low. While it waits, req_ready of that port is low.
- R5: A refused request never raises fwd_valid. It raises err_valid on its port for exactly the one cycle after acceptance.
- R6: irq rises in the cycle after err_valid is high on either port. It then stays high until it is cleared.
- R7: Writing a value with bit 0 set to register address 3 clears irq on the next cycle. When err_valid is high on either port in the same cycle as that write, irq stays high.
- R8: While irq is low, a refusal captures its address (read at register 4) and its details (register 5: bit 1 = port number, bit 0 = 1 for a write). The capture is held while irq stays high. When both ports fail in the same cycle, port 0 is captured.
- R9: After reset the attribute word is 0x00000001, the ID-access word is 0x00000000 and the control register is 0. irq is low, both req_ready are high, and no fwd_valid or err_valid is high.
- R10: Register reads go through a register. reg_rd_data shows the register selected by reg_rd_addr one cycle after the address is applied (0 attribute, 1 ID-access, 2 control, 3 irq in bit 0, 4 failing address, 5 failure details).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset for all state |
| req_valid | input | 2 | Request valid, one bit per port |
| req_ready | output | 2 | Request ready, one bit per port |
| req_addr | input | 2x32 | Request address per port |
| req_write | input | 2 | 1 = write, 0 = read, per port |
| req_secure | input | 2 | 1 = secure request, per port |
| req_debug | input | 2 | Debug flag per port |
| req_id | input | 2x4 | Non-secure access ID per port |
| fwd_valid | output | 2 | Allowed request presented downstream, per port |
| fwd_ready | input | 2 | Downstream accepts the forwarded request, per port |
| fwd_addr | output | 2x32 | Forwarded address per port |
| fwd_write | output | 2 | Forwarded direction per port |
| err_valid | output | 2 | One-cycle error response for a refused request, per port |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 3 | Register write address |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_addr | input | 3 | Register read address |
| reg_rd_data | output | 32 | Registered read data |
| irq | output | 1 | Shared sticky failed-access interrupt |

## Verification
Two pairs of functions can land on the same clock edge. The first pair is a software clear of the interrupt and a new refusal reaching err_valid. The bench sets this up by writing the clear in the very cycle the error response of a refused request is high, and then requires irq to stay high. A clear written alone must bring irq low. The second pair is refusals on both ports at once. The bench sends them in the same cycle and requires the latched address and details to belong to port 0.

// File: rtl/mpg_pkg.sv
package mpg_pkg;
  localparam int NPORT  = 2;
  localparam int REG_AW = 3;
  localparam int DATA_W = 32;

  localparam logic [REG_AW-1:0] RA_ATTR  = 3'd0;
  localparam logic [REG_AW-1:0] RA_IDACC = 3'd1;
  localparam logic [REG_AW-1:0] RA_CTRL  = 3'd2;
  localparam logic [REG_AW-1:0] RA_CLR   = 3'd3;
  localparam logic [REG_AW-1:0] RA_FADDR = 3'd4;
  localparam logic [REG_AW-1:0] RA_FINFO = 3'd5;
endpackage

// File: rtl/mpg_decide.sv
module mpg_decide #(
  parameter int ID_W   = 4,
  parameter int ATTR_W = 32,
  localparam int IDACC_W = 2 * (1 << ID_W)
) (
  input  logic [ATTR_W-1:0]  attr,
  input  logic [IDACC_W-1:0] idacc,
  input  logic               dbg_pass,
  input  logic               secure,
  input  logic               write,
  input  logic               debug,
  input  logic [ID_W-1:0]    id,
  output logic               allow
);
  logic sec_ok;
  logic ns_ok;

  // Top two attribute bits: write enable above read enable.
  assign sec_ok = write ? attr[ATTR_W-1] : attr[ATTR_W-2];
  // Upper half of the ID word holds write enables, lower half read enables.
  assign ns_ok  = idacc[{write, id}];
  assign allow  = (dbg_pass & debug) | (secure ? sec_ok : ns_ok);
endmodule

// File: rtl/mpg_port.sv
module mpg_port #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              allow,
  output logic              fwd_valid,
  input  logic              fwd_ready,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic              fwd_write,
  output logic              err_valid
);
  logic              full_q;
  logic              blk_q;
  logic [ADDR_W-1:0] addr_q;
  logic              wr_q;

  // The slot frees when empty, when it holds an error (one cycle only),
  // or when downstream takes the forwarded request.
  assign req_ready = ~full_q | blk_q | fwd_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
    end else if (req_ready) begin
      full_q <= req_valid;
    end
    if (req_valid && req_ready) begin
      blk_q  <= ~allow;
      addr_q <= req_addr;
      wr_q   <= req_write;
    end
  end

  assign fwd_valid = full_q & ~blk_q;
  assign err_valid = full_q & blk_q;
  assign fwd_addr  = addr_q;
  assign fwd_write = wr_q;
endmodule

// File: rtl/mpg_regs.sv
module mpg_regs
  import mpg_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          ATTR_W    = 32,
  parameter int          IDACC_W   = 32,
  parameter logic [31:0] ATTR_RST  = 32'h0000_0001,
  parameter logic [31:0] IDACC_RST = 32'h0000_0000,
  localparam int PORT_W = $clog2(NPORT)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [REG_AW-1:0]             wr_addr,
  input  logic [DATA_W-1:0]             wr_data,
  input  logic [REG_AW-1:0]             rd_addr,
  output logic [DATA_W-1:0]             rd_data,
  input  logic [NPORT-1:0]              err_valid,
  input  logic [NPORT-1:0][ADDR_W-1:0]  err_addr,
  input  logic [NPORT-1:0]              err_write,
  output logic [ATTR_W-1:0]             attr_q,
  output logic [IDACC_W-1:0]            idacc_q,
  output logic                          dbg_pass_q,
  output logic                          irq_q,
  output logic [ADDR_W-1:0]             fail_addr_q
);
  logic [PORT_W-1:0] sel;
  logic              any_err;
  logic              clr;
  logic [PORT_W-1:0] fail_port_q;
  logic              fail_write_q;

  // Lowest-numbered failing port wins the capture.
  always_comb begin
    sel = '0;
    for (int i = NPORT - 1; i >= 0; i--) begin
      if (err_valid[i]) sel = PORT_W'(i);
    end
  end

  assign any_err = |err_valid;
  assign clr     = wr_en && (wr_addr == RA_CLR) && wr_data[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      attr_q     <= ATTR_W'(ATTR_RST);
      idacc_q    <= IDACC_W'(IDACC_RST);
      dbg_pass_q <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      if (wr_en && wr_addr == RA_ATTR)  attr_q     <= wr_data[ATTR_W-1:0];
      if (wr_en && wr_addr == RA_IDACC) idacc_q    <= wr_data[IDACC_W-1:0];
      if (wr_en && wr_addr == RA_CTRL)  dbg_pass_q <= wr_data[0];
      if (any_err)  irq_q <= 1'b1;
      else if (clr) irq_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fail_addr_q  <= '0;
      fail_port_q  <= '0;
      fail_write_q <= 1'b0;
    end else if (any_err && !irq_q) begin
      fail_addr_q  <= err_addr[sel];
      fail_port_q  <= sel;
      fail_write_q <= err_write[sel];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (rd_addr)
        RA_ATTR:  rd_data <= DATA_W'(attr_q);
        RA_IDACC: rd_data <= DATA_W'(idacc_q);
        RA_CTRL:  rd_data <= DATA_W'(dbg_pass_q);
        RA_CLR:   rd_data <= DATA_W'(irq_q);
        RA_FADDR: rd_data <= DATA_W'(fail_addr_q);
        RA_FINFO: rd_data <= DATA_W'({fail_port_q, fail_write_q});
        default:  rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/mem_perm_guard.sv
module mem_perm_guard
  import mpg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ID_W   = 4,
  parameter int ATTR_W = 32,
  localparam int IDACC_W = 2 * (1 << ID_W)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NPORT-1:0]             req_valid,
  output logic [NPORT-1:0]             req_ready,
  input  logic [NPORT-1:0][ADDR_W-1:0] req_addr,
  input  logic [NPORT-1:0]             req_write,
  input  logic [NPORT-1:0]             req_secure,
  input  logic [NPORT-1:0]             req_debug,
  input  logic [NPORT-1:0][ID_W-1:0]   req_id,
  output logic [NPORT-1:0]             fwd_valid,
  input  logic [NPORT-1:0]             fwd_ready,
  output logic [NPORT-1:0][ADDR_W-1:0] fwd_addr,
  output logic [NPORT-1:0]             fwd_write,
  output logic [NPORT-1:0]             err_valid,
  input  logic                         reg_wr_en,
  input  logic [REG_AW-1:0]            reg_wr_addr,
  input  logic [DATA_W-1:0]            reg_wr_data,
  input  logic [REG_AW-1:0]            reg_rd_addr,
  output logic [DATA_W-1:0]            reg_rd_data,
  output logic                         irq
);
  logic [ATTR_W-1:0]  attr_w;
  logic [IDACC_W-1:0] idacc_w;
  logic               dbg_pass_w;
  logic [ADDR_W-1:0]  fail_addr_w;
  logic [NPORT-1:0]   allow_w;

  genvar gi;
  generate
    for (gi = 0; gi < NPORT; gi++) begin : g_port
      mpg_decide #(.ID_W(ID_W), .ATTR_W(ATTR_W)) i_decide (
        .attr     (attr_w),
        .idacc    (idacc_w),
        .dbg_pass (dbg_pass_w),
        .secure   (req_secure[gi]),
        .write    (req_write[gi]),
        .debug    (req_debug[gi]),
        .id       (req_id[gi]),
        .allow    (allow_w[gi])
      );
      mpg_port #(.ADDR_W(ADDR_W)) i_port (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid[gi]),
        .req_ready (req_ready[gi]),
        .req_addr  (req_addr[gi]),
        .req_write (req_write[gi]),
        .allow     (allow_w[gi]),
        .fwd_valid (fwd_valid[gi]),
        .fwd_ready (fwd_ready[gi]),
        .fwd_addr  (fwd_addr[gi]),
        .fwd_write (fwd_write[gi]),
        .err_valid (err_valid[gi])
      );
    end
  endgenerate

  mpg_regs #(.ADDR_W(ADDR_W), .ATTR_W(ATTR_W), .IDACC_W(IDACC_W)) i_regs (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (reg_wr_en),
    .wr_addr     (reg_wr_addr),
    .wr_data     (reg_wr_data),
    .rd_addr     (reg_rd_addr),
    .rd_data     (reg_rd_data),
    .err_valid   (err_valid),
    .err_addr    (fwd_addr),
    .err_write   (fwd_write),
    .attr_q      (attr_w),
    .idacc_q     (idacc_w),
    .dbg_pass_q  (dbg_pass_w),
    .irq_q       (irq),
    .fail_addr_q (fail_addr_w)
  );
endmodule

// File: rtl/mem_perm_guard_chk.sv
module mem_perm_guard_chk
  import mpg_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic                         clk,
  input logic                         rst,
  input logic [NPORT-1:0]             req_ready,
  input logic [NPORT-1:0]             fwd_valid,
  input logic [NPORT-1:0]             fwd_ready,
  input logic [NPORT-1:0][ADDR_W-1:0] fwd_addr,
  input logic [NPORT-1:0]             err_valid,
  input logic                         reg_wr_en,
  input logic [REG_AW-1:0]            reg_wr_addr,
  input logic [DATA_W-1:0]            reg_wr_data,
  input logic                         irq,
  input logic [ADDR_W-1:0]            fail_addr_w
);
  logic clr_req;
  assign clr_req = reg_wr_en && (reg_wr_addr == RA_CLR) && reg_wr_data[0];

  p_reset_state_r9: assert property (@(posedge clk)
    rst |=> (!irq && fwd_valid == '0 && err_valid == '0 && req_ready == '1));

  p_irq_set_r6: assert property (@(posedge clk) disable iff (rst)
    (|err_valid) |=> irq);

  p_irq_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (irq && !clr_req) |=> irq);

  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (irq && clr_req && !(|err_valid)) |=> !irq);

  p_capture_hold_r8: assert property (@(posedge clk) disable iff (rst)
    irq |=> $stable(fail_addr_w));

  genvar gi;
  generate
    for (gi = 0; gi < NPORT; gi++) begin : g_chk
      p_fwd_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (fwd_valid[gi] && !fwd_ready[gi]) |=> (fwd_valid[gi] && $stable(fwd_addr[gi])));
      p_stall_r4: assert property (@(posedge clk) disable iff (rst)
        (fwd_valid[gi] && !fwd_ready[gi]) |-> !req_ready[gi]);
      p_err_not_fwd_r5: assert property (@(posedge clk) disable iff (rst)
        err_valid[gi] |-> req_ready[gi]);
    end
  endgenerate
endmodule

bind mem_perm_guard mem_perm_guard_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk         (clk),
  .rst         (rst),
  .req_ready   (req_ready),
  .fwd_valid   (fwd_valid),
  .fwd_ready   (fwd_ready),
  .fwd_addr    (fwd_addr),
  .err_valid   (err_valid),
  .reg_wr_en   (reg_wr_en),
  .reg_wr_addr (reg_wr_addr),
  .reg_wr_data (reg_wr_data),
  .irq         (irq),
  .fail_addr_w (fail_addr_w)
);

// File: tb/test_mem_perm_guard.sv
module test_mem_perm_guard;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 16;

  typedef struct packed {
    logic [1:0]  sec_en;
    logic [31:0] idacc;
    logic        dbg_on;
    logic        sec;
    logic        wr;
    logic        dbg;
    logic [3:0]  id;
    logic        port;
    logic        exp;
    logic [3:0]  rq;
  } vec_t;

  // rq holds the requirement number: R1 secure, R2 non-secure, R3 debug.
  localparam vec_t VEC [NV] = '{
    '{2'b01, 32'h0000_0000, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0,  1'b0, 1'b1, 4'd1},
    '{2'b01, 32'h0000_0000, 1'b0, 1'b1, 1'b1, 1'b0, 4'd0,  1'b0, 1'b0, 4'd1},
    '{2'b10, 32'h0000_0000, 1'b0, 1'b1, 1'b1, 1'b0, 4'd0,  1'b1, 1'b1, 4'd1},
    '{2'b10, 32'h0000_0000, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0,  1'b1, 1'b0, 4'd1},
    '{2'b00, 32'h0000_0020, 1'b0, 1'b0, 1'b0, 1'b0, 4'd5,  1'b0, 1'b1, 4'd2},
    '{2'b00, 32'h0000_0020, 1'b0, 1'b0, 1'b1, 1'b0, 4'd5,  1'b0, 1'b0, 4'd2},
    '{2'b00, 32'h0020_0000, 1'b0, 1'b0, 1'b1, 1'b0, 4'd5,  1'b1, 1'b1, 4'd2},
    '{2'b00, 32'h8000_0000, 1'b0, 1'b0, 1'b0, 1'b0, 4'd15, 1'b0, 1'b0, 4'd2},
    '{2'b00, 32'h8000_0000, 1'b0, 1'b0, 1'b1, 1'b0, 4'd15, 1'b1, 1'b1, 4'd2},
    '{2'b00, 32'h0000_0001, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0,  1'b1, 1'b1, 4'd2},
    '{2'b00, 32'h0000_0000, 1'b1, 1'b0, 1'b0, 1'b1, 4'd2,  1'b0, 1'b1, 4'd3},
    '{2'b00, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b1, 4'd2,  1'b0, 1'b0, 4'd3},
    '{2'b00, 32'h0000_0000, 1'b1, 1'b1, 1'b1, 1'b1, 4'd0,  1'b1, 1'b1, 4'd3},
    '{2'b00, 32'h0000_0000, 1'b1, 1'b0, 1'b0, 1'b0, 4'd2,  1'b1, 1'b0, 4'd3},
    '{2'b00, 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0,  1'b0, 1'b0, 4'd1},
    '{2'b11, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3,  1'b1, 1'b0, 4'd2}
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [1:0]       req_valid = '0;
  logic [1:0]       req_ready;
  logic [1:0][31:0] req_addr = '0;
  logic [1:0]       req_write = '0;
  logic [1:0]       req_secure = '0;
  logic [1:0]       req_debug = '0;
  logic [1:0][3:0]  req_id = '0;
  logic [1:0]       fwd_valid;
  logic [1:0]       fwd_ready = 2'b11;
  logic [1:0][31:0] fwd_addr;
  logic [1:0]       fwd_write;
  logic [1:0]       err_valid;
  logic             reg_wr_en = 1'b0;
  logic [2:0]       reg_wr_addr = '0;
  logic [31:0]      reg_wr_data = '0;
  logic [2:0]       reg_rd_addr = '0;
  logic [31:0]      reg_rd_data;
  logic             irq;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mem_perm_guard i_mem_perm_guard (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_secure(req_secure), .req_debug(req_debug),
    .req_id(req_id), .fwd_valid(fwd_valid), .fwd_ready(fwd_ready),
    .fwd_addr(fwd_addr), .fwd_write(fwd_write), .err_valid(err_valid),
    .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd_addr = a;
    @(negedge clk);
    d = reg_rd_data;
  endtask

  task automatic set_req(input int p, input logic [31:0] a, input logic w,
                         input logic s, input logic dg, input logic [3:0] id);
    req_valid[p] = 1'b1; req_addr[p] = a; req_write[p] = w;
    req_secure[p] = s; req_debug[p] = dg; req_id[p] = id;
  endtask

  // Drives one request, samples the cycle after acceptance, then idles a cycle.
  task automatic send(input int p, input logic [31:0] a, input logic w,
                      input logic s, input logic dg, input logic [3:0] id,
                      output logic f, output logic e, output logic [31:0] fa);
    @(negedge clk);
    set_req(p, a, w, s, dg, id);
    @(negedge clk);
    f = fwd_valid[p]; e = err_valid[p]; fa = fwd_addr[p];
    req_valid[p] = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic f, e;
    logic [31:0] fa;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R9 reset state
    chk(irq == 1'b0, "R9 irq", 32'(irq), 0);
    chk(req_ready == 2'b11, "R9 ready", 32'(req_ready), 3);
    chk(fwd_valid == 2'b00 && err_valid == 2'b00, "R9 no output",
        32'({fwd_valid, err_valid}), 0);
    rd_reg(3'd0, d); chk(d == 32'h1, "R9 attr", d, 32'h1);
    rd_reg(3'd1, d); chk(d == 32'h0, "R9 idacc", d, 32'h0);
    rd_reg(3'd2, d); chk(d == 32'h0, "R9 ctrl", d, 32'h0);

    // Vector table: R1, R2, R3 decisions plus R4/R5 forward-or-error.
    for (int i = 0; i < NV; i++) begin
      wr_reg(3'd0, {VEC[i].sec_en, 30'h0});
      wr_reg(3'd1, VEC[i].idacc);
      wr_reg(3'd2, {31'h0, VEC[i].dbg_on});
      send(int'(VEC[i].port), 32'h1000_0000 + 32'(i * 4), VEC[i].wr, VEC[i].sec,
           VEC[i].dbg, VEC[i].id, f, e, fa);
      chk(f == VEC[i].exp && e == !VEC[i].exp,
          $sformatf("R%0d vector %0d fwd/err", VEC[i].rq, i), 32'({f, e}),
          32'({VEC[i].exp, !VEC[i].exp}));
      if (VEC[i].exp)
        chk(fa == 32'h1000_0000 + 32'(i * 4), $sformatf("R4 vector %0d addr", i),
            fa, 32'h1000_0000 + 32'(i * 4));
      else
        chk(err_valid == 2'b00, $sformatf("R5 vector %0d err one cycle", i),
            32'(err_valid), 0);
    end

    // R6 / R8: first failure captured, held across a second failure.
    wr_reg(3'd0, 32'h0);
    wr_reg(3'd1, 32'h0);
    wr_reg(3'd2, 32'h0);
    wr_reg(3'd3, 32'h1);
    chk(irq == 1'b0, "R7 clear alone", 32'(irq), 0);
    send(1, 32'hA000_0010, 1'b0, 1'b0, 1'b0, 4'd1, f, e, fa);
    chk(irq == 1'b1, "R6 irq set from port 1", 32'(irq), 1);
    rd_reg(3'd4, d); chk(d == 32'hA000_0010, "R8 capture addr", d, 32'hA000_0010);
    rd_reg(3'd5, d); chk(d == 32'h2, "R8 capture port1 read", d, 32'h2);
    send(0, 32'hA000_0020, 1'b1, 1'b0, 1'b0, 4'd2, f, e, fa);
    repeat (3) @(negedge clk);
    chk(irq == 1'b1, "R6 irq sticky", 32'(irq), 1);
    rd_reg(3'd4, d); chk(d == 32'hA000_0010, "R8 capture held", d, 32'hA000_0010);
    rd_reg(3'd3, d); chk(d == 32'h1, "R10 irq readback", d, 32'h1);

    // R7: clear written in the same cycle as an error response.
    @(negedge clk);
    set_req(0, 32'hA000_0030, 1'b0, 1'b0, 1'b0, 4'd3);
    @(negedge clk);
    req_valid[0] = 1'b0;
    reg_wr_en = 1'b1; reg_wr_addr = 3'd3; reg_wr_data = 32'h1;
    chk(err_valid[0] == 1'b1, "R7 error present with clear", 32'(err_valid), 1);
    @(negedge clk);
    reg_wr_en = 1'b0;
    chk(irq == 1'b1, "R7 fail beats clear", 32'(irq), 1);
    wr_reg(3'd3, 32'h1);
    chk(irq == 1'b0, "R7 clear", 32'(irq), 0);

    // R8: both ports fail in one cycle, port 0 captured.
    @(negedge clk);
    set_req(0, 32'hB000_0000, 1'b1, 1'b0, 1'b0, 4'd4);
    set_req(1, 32'hB000_0100, 1'b0, 1'b0, 1'b0, 4'd5);
    @(negedge clk);
    chk(err_valid == 2'b11, "R5 both errors", 32'(err_valid), 3);
    req_valid = 2'b00;
    @(negedge clk);
    rd_reg(3'd4, d); chk(d == 32'hB000_0000, "R8 port0 priority addr", d, 32'hB000_0000);
    rd_reg(3'd5, d); chk(d == 32'h1, "R8 port0 write info", d, 32'h1);

    // R4: backpressure holds forwarded request and stalls the port.
    wr_reg(3'd1, 32'h0000_FFFF);
    fwd_ready[0] = 1'b0;
    @(negedge clk);
    set_req(0, 32'hC000_0040, 1'b0, 1'b0, 1'b0, 4'd7);
    @(negedge clk);
    req_valid[0] = 1'b0;
    chk(fwd_valid[0] == 1'b1 && req_ready[0] == 1'b0, "R4 held and stalled",
        32'({fwd_valid[0], req_ready[0]}), 32'h2);
    @(negedge clk);
    chk(fwd_valid[0] == 1'b1 && fwd_addr[0] == 32'hC000_0040, "R4 stable addr",
        fwd_addr[0], 32'hC000_0040);
    fwd_ready[0] = 1'b1;
    @(negedge clk);
    chk(fwd_valid[0] == 1'b0 && req_ready[0] == 1'b1, "R4 drained",
        32'({fwd_valid[0], req_ready[0]}), 32'h1);

    // R10: read data lags the address by one cycle.
    rd_reg(3'd1, d); chk(d == 32'h0000_FFFF, "R10 idacc read", d, 32'h0000_FFFF);
    @(negedge clk);
    reg_rd_addr = 3'd0;
    #1;
    chk(reg_rd_data == 32'h0000_FFFF, "R10 old data before edge", reg_rd_data, 32'h0000_FFFF);
    @(negedge clk);
    chk(reg_rd_data == 32'h0, "R10 new data after edge", reg_rd_data, 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule